// File: doc/BRIEF.md
# Parallel Bus Panel Write Engine

This block drives an 8080-style parallel write bus toward a display panel that holds its own frame memory. Once a frame transfer is started it takes pixel words one at a time from a ready/valid stream and plays each one out as a bus write cycle. Each cycle has four phases whose lengths are programmed in clock cycles: a chip-select lead-in, a write-strobe lead-in, the strobe-low interval and a hold tail. Between words the chip select returns high. When the stream has no word ready, the sequencer waits with the bus idle.

A frame starts in one of two ways. Software can write a command bit. Alternatively, the rising edge of the panel's tearing-effect (TE) input can start it if the hardware path is armed and unmasked. The hardware path can be one-shot or can fire on every TE edge. A trigger that arrives while a frame is running is dropped. The frame size comes from programmable line-width and line-count fields. When the last word finishes, the busy flag drops and a sticky frame-done interrupt is set. Software clears the interrupt by writing one to it.

Control goes through a small register port: a write strobe, a two-bit address, write data and a combinational read-back.

Top module: `i80_wr_engine`

## Requirements
- R1: Register 0 (timing) holds the chip-select lead-in in bits [19:16], the strobe lead-in in [15:12], the strobe-active code in [11:8], the hold in [7:4] and the interface enable in bit 0. It reads back only those bits. After reset it reads 0x00000100, so the active code is 1 and all other fields are 0.
- R2: For each word with lead-ins CS and WS, active code A and hold H, the chip select is low for CS+WS+A+1+H consecutive cycles. The strobe is low for exactly A+1 of those cycles, starting CS+WS cycles after the chip select falls.
- R3: The data bus holds one value for the whole time the chip select is low. That value is the accepted stream word, and words are sent in the order they were accepted.
- R4: The pixel input is ready only while the chip select is high and a frame is in progress. While no word is valid, the chip select stays high and no strobe occurs.
- R5: Register 2 holds (words per line − 1) in bits [7:0] and (lines − 1) in bits [23:16]. A frame writes exactly their product of words.
- R6: Register 1 (trigger) has these fields: bit 0 software mode, bit 1 command, bit 3 hardware enable, bit 4 hardware mask, bit 31 fire-on-every-TE. A write with bits 0 and 1 both set starts a frame. A write of the command with bit 0 clear starts nothing. Bit 1 always reads 0.
- R7: A TE rising edge starts a frame only when hardware enable is 1, mask is 0 and software mode is 0.
- R8: When fire-on-every-TE is 0, an accepted hardware trigger clears the hardware-enable bit, so the next TE edge is ignored. When it is 1, the enable stays set and every TE edge starts a frame.
- R9: A software or TE trigger that arrives while busy is ignored, and no further frame follows.
- R10: With the interface enable at 0, no trigger of either kind starts a frame.
- R11: Busy reads 0 after reset. It is 1 at the first cycle after an accepted trigger and falls when the hold of the last word ends. Register 3 bit 1 reads busy.
- R12: Register 3 bit 0 is the frame-done interrupt and drives frame_irq. It is set when a frame finishes and stays set until a write with bit 0 = 1 clears it. A write with bit 0 = 0 leaves it set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select (0 timing, 1 trigger, 2 size, 3 status) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read-back of the selected register |
| te_in | input | 1 | Tearing-effect input from the panel, synchronous |
| pix_valid | input | 1 | Pixel word valid |
| pix_data | input | 16 | Pixel word |
| pix_ready | output | 1 | Engine accepts the pixel word this cycle |
| lcd_cs_n | output | 1 | Bus chip select, active low |
| lcd_wr_n | output | 1 | Bus write strobe, active low |
| lcd_db | output | 16 | Bus data |
| busy | output | 1 | Frame transfer in progress |
| frame_irq | output | 1 | Frame-done interrupt status |

## Verification
The properties assume that te_in is already synchronous to clk. They also assume the timing and size registers are not rewritten while busy is high, since the sequencer reads those fields live. The stimulus changes configuration only after busy has dropped, holds TE high for two cycles per pulse, and changes pixel inputs only on falling clock edges. The stream source sometimes withholds valid so that the waiting path is exercised.

// File: rtl/i80_wr_pkg.sv
package i80_wr_pkg;
  localparam int PH_W   = 4;
  localparam int REG_W  = 32;

  localparam logic [1:0] ADDR_TIMING = 2'd0;
  localparam logic [1:0] ADDR_TRIG   = 2'd1;
  localparam logic [1:0] ADDR_SIZE   = 2'd2;
  localparam logic [1:0] ADDR_STAT   = 2'd3;

  localparam int TM_CS_LSB = 16;
  localparam int TM_WS_LSB = 12;
  localparam int TM_WA_LSB = 8;
  localparam int TM_WH_LSB = 4;
  localparam int TM_EN_BIT = 0;

  localparam int TG_MODE_BIT  = 0;
  localparam int TG_CMD_BIT   = 1;
  localparam int TG_HWEN_BIT  = 3;
  localparam int TG_MASK_BIT  = 4;
  localparam int TG_PERTE_BIT = 31;

  localparam int SZ_H_LSB = 16;

  typedef enum logic [2:0] {
    ST_IDLE, ST_WAIT, ST_CSU, ST_WSU, ST_ACT, ST_HLD
  } seq_state_e;

  typedef struct packed {
    logic [PH_W-1:0] cs_setup;
    logic [PH_W-1:0] wr_setup;
    logic [PH_W-1:0] wr_active;
    logic [PH_W-1:0] wr_hold;
  } strobe_timing_t;
endpackage

// File: rtl/i80_wr_regs.sv
module i80_wr_regs
  import i80_wr_pkg::*;
#(
  parameter int DIM_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 reg_we,
  input  logic [1:0]           reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  input  logic                 te_i,
  input  logic                 seq_busy_i,
  input  logic                 seq_done_i,
  output strobe_timing_t       tim_o,
  output logic [DIM_W-1:0]     wlast_o,
  output logic [DIM_W-1:0]     hlast_o,
  output logic                 start_o,
  output logic                 irq_o
);
  localparam int PAD_W = 16 - DIM_W;

  logic [PH_W-1:0] cs_q, cs_d, ws_q, ws_d, wa_q, wa_d, wh_q, wh_d;
  logic [DIM_W-1:0] wl_q, wl_d, hl_q, hl_d;
  logic en_q, en_d, mode_q, mode_d, hwen_q, hwen_d;
  logic mask_q, mask_d, perte_q, perte_d, irq_q, irq_d, te_q;
  logic wr_tim, wr_trg, wr_size, wr_stat;
  logic sw_fire, hw_fire, te_rise;
  logic unused_wdata;

  assign unused_wdata = ^{reg_wdata[30:20], reg_wdata[2]};

  assign wr_tim  = reg_we && (reg_addr == ADDR_TIMING);
  assign wr_trg  = reg_we && (reg_addr == ADDR_TRIG);
  assign wr_size = reg_we && (reg_addr == ADDR_SIZE);
  assign wr_stat = reg_we && (reg_addr == ADDR_STAT);

  assign te_rise = te_i && !te_q;
  assign sw_fire = wr_trg && reg_wdata[TG_CMD_BIT] && reg_wdata[TG_MODE_BIT];
  assign hw_fire = te_rise && hwen_q && !mask_q && !mode_q;
  assign start_o = en_q && !seq_busy_i && (sw_fire || hw_fire);

  always_comb begin
    cs_d = cs_q; ws_d = ws_q; wa_d = wa_q; wh_d = wh_q; en_d = en_q;
    mode_d = mode_q; hwen_d = hwen_q; mask_d = mask_q; perte_d = perte_q;
    wl_d = wl_q; hl_d = hl_q;
    if (wr_tim) begin
      cs_d = reg_wdata[TM_CS_LSB +: PH_W];
      ws_d = reg_wdata[TM_WS_LSB +: PH_W];
      wa_d = reg_wdata[TM_WA_LSB +: PH_W];
      wh_d = reg_wdata[TM_WH_LSB +: PH_W];
      en_d = reg_wdata[TM_EN_BIT];
    end
    if (start_o && hw_fire && !perte_q) hwen_d = 1'b0;
    if (wr_trg) begin
      mode_d  = reg_wdata[TG_MODE_BIT];
      hwen_d  = reg_wdata[TG_HWEN_BIT];
      mask_d  = reg_wdata[TG_MASK_BIT];
      perte_d = reg_wdata[TG_PERTE_BIT];
    end
    if (wr_size) begin
      wl_d = reg_wdata[0 +: DIM_W];
      hl_d = reg_wdata[SZ_H_LSB +: DIM_W];
    end
    irq_d = (irq_q && !(wr_stat && reg_wdata[0])) || seq_done_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= '0; ws_q <= '0; wa_q <= PH_W'(1); wh_q <= '0; en_q <= 1'b0;
      mode_q <= 1'b0; hwen_q <= 1'b0; mask_q <= 1'b0; perte_q <= 1'b0;
      wl_q <= '0; hl_q <= '0; irq_q <= 1'b0; te_q <= 1'b0;
    end else begin
      cs_q <= cs_d; ws_q <= ws_d; wa_q <= wa_d; wh_q <= wh_d; en_q <= en_d;
      mode_q <= mode_d; hwen_q <= hwen_d; mask_q <= mask_d; perte_q <= perte_d;
      wl_q <= wl_d; hl_q <= hl_d; irq_q <= irq_d; te_q <= te_i;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_TIMING: begin
        reg_rdata[TM_CS_LSB +: PH_W] = cs_q;
        reg_rdata[TM_WS_LSB +: PH_W] = ws_q;
        reg_rdata[TM_WA_LSB +: PH_W] = wa_q;
        reg_rdata[TM_WH_LSB +: PH_W] = wh_q;
        reg_rdata[TM_EN_BIT]         = en_q;
      end
      ADDR_TRIG: begin
        reg_rdata[TG_MODE_BIT]  = mode_q;
        reg_rdata[TG_HWEN_BIT]  = hwen_q;
        reg_rdata[TG_MASK_BIT]  = mask_q;
        reg_rdata[TG_PERTE_BIT] = perte_q;
      end
      ADDR_SIZE: reg_rdata = {{PAD_W{1'b0}}, hl_q, {PAD_W{1'b0}}, wl_q};
      default:   reg_rdata[1:0] = {seq_busy_i, irq_q};
    endcase
  end

  assign tim_o   = '{cs_setup: cs_q, wr_setup: ws_q, wr_active: wa_q, wr_hold: wh_q};
  assign wlast_o = wl_q;
  assign hlast_o = hl_q;
  assign irq_o   = irq_q;
endmodule

// File: rtl/i80_wr_seq.sv
module i80_wr_seq
  import i80_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  strobe_timing_t    tim_i,
  input  logic [DIM_W-1:0]  wlast_i,
  input  logic [DIM_W-1:0]  hlast_i,
  input  logic              pix_valid_i,
  input  logic [DATA_W-1:0] pix_data_i,
  output logic              pix_ready_o,
  output logic              cs_n_o,
  output logic              wr_n_o,
  output logic [DATA_W-1:0] db_o,
  output logic              busy_o,
  output logic              done_o
);
  seq_state_e st_q, st_d;
  logic [PH_W-1:0] cnt_q, cnt_d;
  logic [DIM_W-1:0] col_q, col_d, row_q, row_d;
  logic [DATA_W-1:0] db_q, db_d;
  logic word_end;

  always_comb begin
    st_d = st_q; cnt_d = cnt_q; col_d = col_q; row_d = row_q; db_d = db_q;
    word_end = 1'b0; done_o = 1'b0;
    case (st_q)
      ST_IDLE: if (start_i) begin
        st_d = ST_WAIT; col_d = '0; row_d = '0;
      end
      ST_WAIT: if (pix_valid_i) begin
        db_d = pix_data_i;
        if (tim_i.cs_setup != '0) begin
          st_d = ST_CSU; cnt_d = tim_i.cs_setup - 1'b1;
        end else if (tim_i.wr_setup != '0) begin
          st_d = ST_WSU; cnt_d = tim_i.wr_setup - 1'b1;
        end else begin
          st_d = ST_ACT; cnt_d = tim_i.wr_active;
        end
      end
      ST_CSU: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (tim_i.wr_setup != '0) begin
          st_d = ST_WSU; cnt_d = tim_i.wr_setup - 1'b1;
        end else begin
          st_d = ST_ACT; cnt_d = tim_i.wr_active;
        end
      ST_WSU: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else begin
          st_d = ST_ACT; cnt_d = tim_i.wr_active;
        end
      ST_ACT: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else if (tim_i.wr_hold != '0) begin
          st_d = ST_HLD; cnt_d = tim_i.wr_hold - 1'b1;
        end else word_end = 1'b1;
      ST_HLD: if (cnt_q != '0) cnt_d = cnt_q - 1'b1;
        else word_end = 1'b1;
      default: st_d = ST_IDLE;
    endcase
    if (word_end) begin
      st_d = ST_WAIT;
      if (col_q == wlast_i) begin
        col_d = '0;
        if (row_q == hlast_i) begin
          st_d = ST_IDLE; done_o = 1'b1;
        end else row_d = row_q + 1'b1;
      end else col_d = col_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; cnt_q <= '0; col_q <= '0; row_q <= '0; db_q <= '0;
    end else begin
      st_q <= st_d; cnt_q <= cnt_d; col_q <= col_d; row_q <= row_d; db_q <= db_d;
    end
  end

  assign pix_ready_o = (st_q == ST_WAIT);
  assign cs_n_o      = (st_q == ST_IDLE) || (st_q == ST_WAIT);
  assign wr_n_o      = (st_q != ST_ACT);
  assign db_o        = db_q;
  assign busy_o      = (st_q != ST_IDLE);
endmodule

// File: rtl/i80_wr_engine.sv
module i80_wr_engine
  import i80_wr_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              te_in,
  input  logic              pix_valid,
  input  logic [DATA_W-1:0] pix_data,
  output logic              pix_ready,
  output logic              lcd_cs_n,
  output logic              lcd_wr_n,
  output logic [DATA_W-1:0] lcd_db,
  output logic              busy,
  output logic              frame_irq
);
  strobe_timing_t   tim;
  logic [DIM_W-1:0] wlast, hlast;
  logic             start, done;

  i80_wr_regs #(.DIM_W(DIM_W)) u_regs (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata,
    .te_i(te_in), .seq_busy_i(busy), .seq_done_i(done),
    .tim_o(tim), .wlast_o(wlast), .hlast_o(hlast),
    .start_o(start), .irq_o(frame_irq)
  );

  i80_wr_seq #(.DATA_W(DATA_W), .DIM_W(DIM_W)) u_seq (
    .clk, .rst_n, .start_i(start), .tim_i(tim),
    .wlast_i(wlast), .hlast_i(hlast),
    .pix_valid_i(pix_valid), .pix_data_i(pix_data), .pix_ready_o(pix_ready),
    .cs_n_o(lcd_cs_n), .wr_n_o(lcd_wr_n), .db_o(lcd_db),
    .busy_o(busy), .done_o(done)
  );
endmodule

// File: rtl/i80_wr_engine_chk.sv
module i80_wr_engine_chk #(
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pix_ready,
  input logic              lcd_cs_n,
  input logic              lcd_wr_n,
  input logic [DATA_W-1:0] lcd_db,
  input logic              busy,
  input logic              frame_irq
);
  assert_wr_in_cs_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_wr_n |-> !lcd_cs_n);

  assert_db_stable_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!lcd_cs_n && $past(!lcd_cs_n)) |-> $stable(lcd_db));

  assert_ready_bus_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    pix_ready |-> (lcd_cs_n && busy));

  assert_cs_needs_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !lcd_cs_n |-> busy);

  assert_irq_at_frame_end_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_irq) |-> $fell(busy));
endmodule

bind i80_wr_engine i80_wr_engine_chk #(.DATA_W(DATA_W)) u_chk (
  .clk, .rst_n, .pix_ready, .lcd_cs_n, .lcd_wr_n, .lcd_db, .busy, .frame_irq
);

// File: tb/i80_wr_engine_tb.sv
module i80_wr_engine_tb;
  localparam logic [15:0] BASE = 16'hA000;

  logic clk = 1'b0;
  logic rst_n, reg_we, te_in, pix_valid;
  logic [1:0] reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic [15:0] pix_data, lcd_db;
  logic pix_ready, lcd_cs_n, lcd_wr_n, busy, frame_irq;

  always #5 clk = ~clk;

  i80_wr_engine u_dut (
    .clk, .rst_n, .reg_we, .reg_addr, .reg_wdata, .reg_rdata, .te_in,
    .pix_valid, .pix_data, .pix_ready, .lcd_cs_n, .lcd_wr_n, .lcd_db,
    .busy, .frame_irq
  );

  int n_chk = 0, n_bad = 0, mon_chk = 0, mon_bad = 0, wd_bad = 0;
  int exp_cs, exp_ws, exp_wa, exp_wh;
  int mon_words = 0;
  int src_idx = 0;
  bit stall_en = 0;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***",
             n_chk + mon_chk + wd_bad, n_bad + mon_bad + wd_bad);
  endtask

  task automatic reg_wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic reg_rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wait_idle();
    int n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
    check(!busy, "R11 busy never fell", busy, 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic pulse_te();
    @(negedge clk); te_in = 1'b1;
    repeat (2) @(negedge clk); te_in = 1'b0;
  endtask

  task automatic set_timing(input int c, input int w, input int a, input int h, input bit en);
    exp_cs = c; exp_ws = w; exp_wa = a; exp_wh = h;
    reg_wr(2'd0, (c << 16) | (w << 12) | (a << 8) | (h << 4) | en);
  endtask

  task automatic sw_frame(input int nwords);
    int w0;
    logic [31:0] d;
    w0 = mon_words;
    reg_wr(2'd1, 32'h3);
    check(busy, "R11 busy after sw trigger", busy, 1);
    wait_idle();
    check(mon_words - w0 == nwords, "R5 words per frame", mon_words - w0, nwords);
    reg_rd(2'd3, d);
    check(d[0] == 1'b1, "R12 irq set at frame end", d[0], 1);
    reg_wr(2'd3, 32'h1);
    reg_rd(2'd3, d);
    check(d[1:0] == 2'b00, "R12 irq cleared by write 1", d[1:0], 0);
  endtask

  // pixel source: words BASE+k in acceptance order
  initial begin
    bit take = 0;
    int cyc = 0;
    pix_valid = 1'b0; pix_data = BASE;
    forever begin
      @(negedge clk);
      cyc++;
      if (take) src_idx++;
      pix_valid = stall_en ? ((cyc % 3) != 1) : 1'b1;
      pix_data = BASE + 16'(src_idx);
      take = pix_valid && pix_ready;
    end
  end

  // bus monitor: checks each word when chip select returns high
  initial begin
    bit prev_lo = 0, rdy_bad = 0;
    int lo = 0, wr = 0, pos = 0;
    logic [15:0] first = '0;
    bit db_bad = 0;
    forever begin
      @(negedge clk);
      if (pix_ready && !lcd_cs_n) rdy_bad = 1;
      if (!lcd_cs_n) begin
        lo++;
        if (lo == 1) first = lcd_db;
        else if (lcd_db != first) db_bad = 1;
        if (!lcd_wr_n) begin
          if (wr == 0) pos = lo - 1;
          wr++;
        end
      end else if (prev_lo) begin
        mon_chk += 4;
        if (lo != exp_cs + exp_ws + exp_wa + 1 + exp_wh) begin
          mon_bad++; $display("FAIL R2 cs low cycles actual=%0d expected=%0d", lo, exp_cs + exp_ws + exp_wa + 1 + exp_wh);
        end
        if (wr != exp_wa + 1 || pos != exp_cs + exp_ws) begin
          mon_bad++; $display("FAIL R2 strobe width/pos actual=%0d/%0d expected=%0d/%0d", wr, pos, exp_wa + 1, exp_cs + exp_ws);
        end
        if (db_bad || first != BASE + 16'(mon_words)) begin
          mon_bad++; $display("FAIL R3 data actual=%0h expected=%0h", first, BASE + 16'(mon_words));
        end
        if (rdy_bad) begin
          mon_bad++; $display("FAIL R4 ready while cs low actual=1 expected=0");
        end
        mon_words++; lo = 0; wr = 0; db_bad = 0; rdy_bad = 0;
      end
      prev_lo = !lcd_cs_n;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    wd_bad = 1;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    logic [31:0] d;
    int w0;
    rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0; te_in = 1'b0;
    exp_cs = 0; exp_ws = 0; exp_wa = 1; exp_wh = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(lcd_cs_n && lcd_wr_n, "R2 bus idle after reset", {lcd_cs_n, lcd_wr_n}, 3);
    check(!busy && !frame_irq, "R11 R12 reset busy/irq", {busy, frame_irq}, 0);
    reg_rd(2'd0, d); check(d == 32'h0000_0100, "R1 timing reset value", d, 32'h100);
    reg_rd(2'd1, d); check(d == 32'h0, "R6 trigger reset value", d, 0);
    reg_wr(2'd0, 32'h0003_4561);
    reg_rd(2'd0, d); check(d == 32'h0003_4561, "R1 timing readback", d, 32'h34561);
    reg_wr(2'd0, 32'hFFFF_FFFF);
    reg_rd(2'd0, d); check(d == 32'h000F_FFF1, "R1 timing field mask", d, 32'hFFFF1);

    // R5: 3 words x 2 lines
    reg_wr(2'd2, (1 << 16) | 2);
    reg_rd(2'd2, d); check(d == 32'h0001_0002, "R5 size readback", d, 32'h10002);

    // R2 sweep over all small phase combinations
    for (int c = 0; c < 3; c++)
      for (int w = 0; w < 3; w++)
        for (int a = 0; a < 3; a++)
          for (int h = 0; h < 3; h++) begin
            set_timing(c, w, a, h, 1'b1);
            sw_frame(6);
          end

    // R4 R3 with stalled stream
    stall_en = 1;
    set_timing(1, 0, 1, 1, 1'b1); sw_frame(6);
    set_timing(0, 0, 0, 0, 1'b1); sw_frame(6);
    stall_en = 0;

    // R5 other sizes
    reg_wr(2'd2, 0); set_timing(1, 1, 0, 1, 1'b1); sw_frame(1);
    reg_wr(2'd2, (2 << 16) | 4); sw_frame(15);
    reg_wr(2'd2, (1 << 16) | 2);

    // R6 command without software mode; command bit reads 0
    w0 = mon_words;
    reg_wr(2'd1, 32'h2); repeat (10) @(negedge clk);
    check(!busy && mon_words == w0, "R6 cmd without mode ignored", busy, 0);
    reg_wr(2'd1, 32'h3);
    reg_rd(2'd1, d); check(d == 32'h1, "R6 cmd bit reads 0", d, 1);
    wait_idle(); reg_wr(2'd3, 1);

    // R12 write 0 does not clear
    sw_frame(6);
    reg_wr(2'd1, 32'h3); wait_idle();
    reg_wr(2'd3, 0); reg_rd(2'd3, d);
    check(d[0], "R12 write 0 keeps irq", d[0], 1);
    reg_wr(2'd3, 1);

    // R9 software retrigger during frame
    set_timing(2, 2, 2, 2, 1'b1);
    w0 = mon_words;
    reg_wr(2'd1, 32'h3); repeat (5) @(negedge clk);
    reg_wr(2'd1, 32'h3);
    wait_idle(); repeat (20) @(negedge clk);
    check(!busy && mon_words - w0 == 6, "R9 sw trigger while busy ignored", mon_words - w0, 6);
    reg_wr(2'd3, 1);

    // R7 hardware path qualification
    set_timing(0, 1, 0, 0, 1'b1);
    reg_wr(2'd1, 32'h18); pulse_te(); repeat (5) @(negedge clk);
    check(!busy, "R7 masked TE ignored", busy, 0);
    reg_wr(2'd1, 32'h9); pulse_te(); repeat (5) @(negedge clk);
    check(!busy, "R7 TE ignored in software mode", busy, 0);
    w0 = mon_words;
    reg_wr(2'd1, 32'h8); pulse_te();
    check(busy, "R7 TE starts frame", busy, 1);
    wait_idle();
    check(mon_words - w0 == 6, "R7 TE frame words", mon_words - w0, 6);
    reg_rd(2'd1, d); check(d[3] == 1'b0, "R8 one-shot clears hw enable", d[3], 0);
    reg_wr(2'd3, 1);
    pulse_te(); repeat (5) @(negedge clk);
    check(!busy, "R8 second TE ignored when one-shot", busy, 0);

    // R8 every TE, R9 TE during frame
    reg_wr(2'd1, 32'h8000_0008);
    for (int k = 0; k < 2; k++) begin
      pulse_te();
      check(busy, "R8 TE fires each time", busy, 1);
      wait_idle();
    end
    reg_rd(2'd1, d); check(d == 32'h8000_0008, "R8 hw enable kept", d, 32'h80000008);
    set_timing(2, 2, 2, 2, 1'b1);
    w0 = mon_words;
    pulse_te(); repeat (4) @(negedge clk); pulse_te();
    wait_idle(); repeat (20) @(negedge clk);
    check(!busy && mon_words - w0 == 6, "R9 TE while busy ignored", mon_words - w0, 6);
    reg_wr(2'd3, 1);

    // R10 interface disabled
    set_timing(0, 0, 0, 0, 1'b0);
    pulse_te(); repeat (5) @(negedge clk);
    check(!busy, "R10 TE with interface off", busy, 0);
    reg_wr(2'd1, 32'h3); repeat (5) @(negedge clk);
    check(!busy, "R10 sw trigger with interface off", busy, 0);
    reg_rd(2'd3, d); check(d[0] == 1'b0, "R10 no irq with interface off", d[0], 0);

    summary();
    $finish;
  end
endmodule